// File: doc/BRIEF.md
# Programmable Oscillator Setup Sequencer

This block configures an external programmable clock generator over a two-wire I2C bus once the system is out of reset. A one-cycle start pulse launches a fixed script of four write transactions. The first sets the device so that register changes are not copied to its non-volatile memory on every write. The second selects the divider-only output path and disables the control inputs. The third loads a 10-bit divider value that the block takes from an input port and left-justifies into two bytes. The fourth is a single command byte that commits the settings to non-volatile storage. The device then produces 133 MHz divided by (N+2); N = 31 gives about 4.03 MHz.

Both bus lines are open-drain. The block only pulls a line low or releases it, and the pull-ups sit outside it. The serial clock period is four "quarter" intervals, each `QTR_CYCLES` system clocks long. The default of 250 gives 100 kHz from a 100 MHz system clock. Every byte must be acknowledged. A missing acknowledge ends the transaction with STOP, raises the error flag and abandons the rest of the script. When the commit succeeds the done flag is raised.

Top module: `osc_cfg_seq`

## Requirements
- R1: After reset both line drivers are released, `done_o` and `err_o` are low, and the bus stays idle until a start pulse.
- R2: Each transaction begins with START (SDA pulled low while SCL is released) and ends with STOP (SDA released while SCL is released). Outside these two conditions SDA changes only while SCL is driven low.
- R3: Bytes go out MSB first with a ninth clock for the acknowledge, and the first byte of every transaction is 0xB0 (bus address 0x58, write).
- R4: The script in bus order is: [0x0D, 0x08], then [0x02, 0x18, 0x00], then [0x01, divider high, divider low], then [0x3F]. Each group is preceded by the address byte and framed as its own transaction.
- R5: The divider bytes are `div[9:2]` followed by `{div[1:0], 6'b0}`, so 31 gives 0x07, 0xC0 and 1023 gives 0xFF, 0xC0. The divider is captured on the accepted start pulse, and later changes of the input do not affect the run.
- R6: If SDA reads released during any acknowledge clock, the block issues STOP, sets `err_o`, and starts no further transaction. `err_o` holds until the next start pulse.
- R7: After the commit byte is acknowledged and STOP is sent, `done_o` rises and holds until reset or the next start pulse. `done_o` and `err_o` are never high together, and both lines are released while either is high.
- R8: A start pulse that arrives while the script is running is ignored.
- R9: Within a byte, successive falling edges of SCL are exactly `4*QTR_CYCLES` system clocks apart.
- R10: A start pulse after completion or error clears both flags and runs the whole script again from the first transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches the script |
| divider_i | input | DIV_W (10) | Divider value N, captured at start |
| sda_in_i | input | 1 | Resolved level of the SDA line (1 = released/high) |
| scl_drv_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drv_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | Script completed and committed |
| err_o | output | 1 | A byte was not acknowledged |

## Verification
The bench targets four corner cases. The first is a missing acknowledge on the very first address byte and on a mid-script register byte. A design that keeps going would put extra bytes on the bus, and one that skips STOP would leave SDA held low. The second is divider values at both extremes (0 and 1023) and a change of the divider input mid-run. A wrong shift or an unlatched input would corrupt the third transaction's data bytes. The third is a second start pulse during a run, which a careless sequencer would use to restart the script and duplicate transactions. The fourth is the SCL spacing inside a byte, which shows an off-by-one in the quarter divider as a wrong period.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;

  localparam logic [6:0] OSC_BUS_ADDR  = 7'h58;
  localparam logic [7:0] WR_ADDR_BYTE  = {OSC_BUS_ADDR, 1'b0};
  localparam logic [7:0] REG_BUSMODE   = 8'h0D;
  localparam logic [7:0] BUSMODE_NOWR  = 8'h08;
  localparam logic [7:0] REG_OUTMUX    = 8'h02;
  localparam logic [7:0] OUTMUX_HI     = 8'h18;
  localparam logic [7:0] OUTMUX_LO     = 8'h00;
  localparam logic [7:0] REG_DIVIDER   = 8'h01;
  localparam logic [7:0] CMD_COMMIT    = 8'h3F;
  localparam int         SCRIPT_LEN    = 13;
  localparam int         IDX_W         = $clog2(SCRIPT_LEN + 1);

  typedef enum logic [1:0] {
    PHY_START = 2'd0,
    PHY_BYTE  = 2'd1,
    PHY_STOP  = 2'd2
  } phy_cmd_t;

  typedef enum logic [1:0] {
    EN_IDLE  = 2'd0,
    EN_START = 2'd1,
    EN_BYTE  = 2'd2,
    EN_STOP  = 2'd3
  } eng_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE       = 3'd0,
    SQ_START_REQ  = 3'd1,
    SQ_START_WAIT = 3'd2,
    SQ_BYTE_REQ   = 3'd3,
    SQ_BYTE_WAIT  = 3'd4,
    SQ_STOP_REQ   = 3'd5,
    SQ_STOP_WAIT  = 3'd6
  } seq_state_t;

endpackage

// File: rtl/osc_cfg_qtick.sv
module osc_cfg_qtick #(
  parameter int QTR_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_LAST);
  assign tick_o = run_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/osc_cfg_bitio.sv
module osc_cfg_bitio
  import osc_cfg_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid_i,
  input  phy_cmd_t cmd_i,
  input  logic [7:0] byte_i,
  input  logic     sda_in_i,
  output logic     ready_o,
  output logic     done_o,
  output logic     nack_o,
  output logic     scl_low_o,
  output logic     sda_low_o
);
  eng_state_t st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       nack_q, nack_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       done_q, done_d;
  logic       tick;
  logic       ack_slot;

  osc_cfg_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (st_q != EN_IDLE),
    .tick_o(tick)
  );

  assign ack_slot = (bit_q == 4'd8);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    nack_d = nack_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    done_d = 1'b0;
    unique case (st_q)
      EN_IDLE: begin
        if (cmd_valid_i) begin
          ph_d  = 2'd0;
          bit_d = 4'd0;
          sh_d  = byte_i;
          unique case (cmd_i)
            PHY_START: st_d = EN_START;
            PHY_BYTE:  st_d = EN_BYTE;
            default:   st_d = EN_STOP;
          endcase
        end
      end
      EN_START: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          unique case (ph_q)
            2'd0: begin scl_d = 1'b0; sda_d = 1'b0; end
            2'd1: sda_d = 1'b1;
            2'd2: scl_d = 1'b1;
            default: begin done_d = 1'b1; st_d = EN_IDLE; end
          endcase
        end
      end
      EN_BYTE: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          unique case (ph_q)
            2'd0: sda_d = ack_slot ? 1'b0 : ~sh_q[7];
            2'd1: scl_d = 1'b0;
            2'd2: if (ack_slot) nack_d = sda_in_i;
            default: begin
              scl_d = 1'b1;
              if (ack_slot) begin
                done_d = 1'b1;
                st_d   = EN_IDLE;
              end else begin
                bit_d = bit_q + 4'd1;
                sh_d  = {sh_q[6:0], 1'b0};
              end
            end
          endcase
        end
      end
      default: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          unique case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: begin done_d = 1'b1; st_d = EN_IDLE; end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      nack_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      nack_q <= nack_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
    end
  end

  assign ready_o   = (st_q == EN_IDLE);
  assign done_o    = done_q;
  assign nack_o    = nack_q;
  assign scl_low_o = scl_q;
  assign sda_low_o = sda_q;
endmodule

// File: rtl/osc_cfg_script.sv
module osc_cfg_script
  import osc_cfg_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [7:0]       byte_o,
  output logic             txn_last_o
);
  localparam int PAD = 16 - DIV_W;

  logic [15:0] div_just;

  assign div_just = 16'(div_i) << PAD;

  always_comb begin
    byte_o     = 8'h00;
    txn_last_o = 1'b0;
    unique case (idx_i)
      IDX_W'(0), IDX_W'(3), IDX_W'(7), IDX_W'(11): byte_o = WR_ADDR_BYTE;
      IDX_W'(1):  byte_o = REG_BUSMODE;
      IDX_W'(2):  begin byte_o = BUSMODE_NOWR; txn_last_o = 1'b1; end
      IDX_W'(4):  byte_o = REG_OUTMUX;
      IDX_W'(5):  byte_o = OUTMUX_HI;
      IDX_W'(6):  begin byte_o = OUTMUX_LO; txn_last_o = 1'b1; end
      IDX_W'(8):  byte_o = REG_DIVIDER;
      IDX_W'(9):  byte_o = div_just[15:8];
      IDX_W'(10): begin byte_o = div_just[7:0]; txn_last_o = 1'b1; end
      IDX_W'(12): begin byte_o = CMD_COMMIT; txn_last_o = 1'b1; end
      default:    txn_last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/osc_cfg_seq.sv
module osc_cfg_seq
  import osc_cfg_pkg::*;
#(
  parameter int QTR_CYCLES = 250,
  parameter int DIV_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] divider_i,
  input  logic             sda_in_i,
  output logic             scl_drv_low_o,
  output logic             sda_drv_low_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_t       sq_q, sq_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             abort_q, abort_d;

  logic             cmd_valid;
  phy_cmd_t         cmd;
  logic [7:0]       cur_byte;
  logic             txn_last;
  logic             eng_ready, eng_done, eng_nack;

  osc_cfg_script #(.DIV_W(DIV_W)) u_script (
    .idx_i     (idx_q),
    .div_i     (div_q),
    .byte_o    (cur_byte),
    .txn_last_o(txn_last)
  );

  osc_cfg_bitio #(.QTR_CYCLES(QTR_CYCLES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid),
    .cmd_i      (cmd),
    .byte_i     (cur_byte),
    .sda_in_i   (sda_in_i),
    .ready_o    (eng_ready),
    .done_o     (eng_done),
    .nack_o     (eng_nack),
    .scl_low_o  (scl_drv_low_o),
    .sda_low_o  (sda_drv_low_o)
  );

  always_comb begin
    sq_d      = sq_q;
    idx_d     = idx_q;
    div_d     = div_q;
    done_d    = done_q;
    err_d     = err_q;
    abort_d   = abort_q;
    cmd_valid = 1'b0;
    cmd       = PHY_START;
    unique case (sq_q)
      SQ_IDLE: begin
        if (start_i) begin
          done_d  = 1'b0;
          err_d   = 1'b0;
          abort_d = 1'b0;
          idx_d   = '0;
          div_d   = divider_i;
          sq_d    = SQ_START_REQ;
        end
      end
      SQ_START_REQ: begin
        cmd_valid = 1'b1;
        cmd       = PHY_START;
        if (eng_ready) sq_d = SQ_START_WAIT;
      end
      SQ_START_WAIT: if (eng_done) sq_d = SQ_BYTE_REQ;
      SQ_BYTE_REQ: begin
        cmd_valid = 1'b1;
        cmd       = PHY_BYTE;
        if (eng_ready) sq_d = SQ_BYTE_WAIT;
      end
      SQ_BYTE_WAIT: begin
        if (eng_done) begin
          if (eng_nack) begin
            abort_d = 1'b1;
            sq_d    = SQ_STOP_REQ;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            sq_d  = txn_last ? SQ_STOP_REQ : SQ_BYTE_REQ;
          end
        end
      end
      SQ_STOP_REQ: begin
        cmd_valid = 1'b1;
        cmd       = PHY_STOP;
        if (eng_ready) sq_d = SQ_STOP_WAIT;
      end
      default: begin
        if (eng_done) begin
          if (abort_q) begin
            err_d = 1'b1;
            sq_d  = SQ_IDLE;
          end else if (idx_q == IDX_W'(SCRIPT_LEN)) begin
            done_d = 1'b1;
            sq_d   = SQ_IDLE;
          end else begin
            sq_d = SQ_START_REQ;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q    <= SQ_IDLE;
      idx_q   <= '0;
      div_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      sq_q    <= sq_d;
      idx_q   <= idx_d;
      div_q   <= div_d;
      done_q  <= done_d;
      err_q   <= err_d;
      abort_q <= abort_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/osc_cfg_chk.sv
module osc_cfg_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scl_low,
  input logic sda_low,
  input logic done_o,
  input logic err_o
);
  AST_START_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && !scl_low && !$past(scl_low)) |=> sda_low); // R2

  AST_STOP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_low) && !scl_low && !$past(scl_low)) |=> (!scl_low && !sda_low)); // R2

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!scl_low && !sda_low)); // R7

  AST_BUSY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> (!done_o && !err_o)); // R10
endmodule

bind osc_cfg_seq osc_cfg_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .scl_low(scl_drv_low_o),
  .sda_low(sda_drv_low_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/test_osc_cfg_seq.sv
module test_osc_cfg_seq;
  localparam int QTR   = 4;
  localparam int DIV_W = 10;
  localparam int EV_START = 256;
  localparam int EV_STOP  = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [DIV_W-1:0] divider_i = '0;
  logic             scl_drv_low, sda_drv_low;
  logic             done_o, err_o;
  logic             pull = 1'b0;
  logic             sda_bus;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  int    nack_at = -1;
  int    byte_cnt = 0;
  bit    finished = 1'b0;

  assign sda_bus = !(sda_drv_low || pull);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osc_cfg_seq #(.QTR_CYCLES(QTR), .DIV_W(DIV_W)) i_osc_cfg_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .divider_i    (divider_i),
    .sda_in_i     (sda_bus),
    .scl_drv_low_o(scl_drv_low),
    .sda_drv_low_o(sda_drv_low),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic expect_run(input int div, input int nack_idx);
    int  seq[13];
    bit  last[13];
    seq = '{8'hB0, 8'h0D, 8'h08, 8'hB0, 8'h02, 8'h18, 8'h00,
            8'hB0, 8'h01, (div >> 2) & 8'hFF, (div & 3) << 6, 8'hB0, 8'h3F};
    last = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 1};
    push(EV_START, "R2");
    for (int i = 0; i < 13; i++) begin
      if (seq[i] == 8'hB0 && (i == 0 || last[i-1])) push(seq[i], "R3");
      else if (i == 9 || i == 10) push(seq[i], "R5");
      else push(seq[i], "R4");
      if (i == nack_idx) begin
        push(EV_STOP, "R6");
        return;
      end
      if (last[i]) begin
        push(EV_STOP, "R2");
        if (i < 12) push(EV_START, "R2");
      end
    end
  endtask

  // monitor side: compare each bus event as it appears
  task automatic see(input int v);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4", "unexpected bus event", v, 0);
    end else begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(v == e, t, "bus event", v, e);
    end
  endtask

  bit       prev_scl_hi = 1'b1;
  bit       prev_sda = 1'b1;
  int       bitcnt = 0;
  bit [7:0] shreg = 8'h00;
  int       last_fall = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit scl_hi;
      scl_hi = !scl_drv_low;
      if (scl_hi && prev_scl_hi && prev_sda && !sda_bus) begin
        see(EV_START);
        bitcnt = 0;
        pull <= 1'b0;
      end else if (scl_hi && prev_scl_hi && !prev_sda && sda_bus) begin
        see(EV_STOP);
        bitcnt = 0;
        pull <= 1'b0;
      end else if (scl_hi && !prev_scl_hi) begin
        bitcnt++;
        if (bitcnt <= 8) shreg = {shreg[6:0], sda_bus};
        if (bitcnt == 8) see(int'(shreg));
      end else if (!scl_hi && prev_scl_hi) begin
        if (bitcnt >= 2 && bitcnt <= 9)
          chk(cyc - last_fall == 4 * QTR, "R9", "SCL fall spacing",
              cyc - last_fall, 4 * QTR);
        last_fall = cyc;
        if (bitcnt == 8 && byte_cnt != nack_at) pull <= 1'b1;
        if (bitcnt == 9) begin
          pull <= 1'b0;
          bitcnt = 0;
          byte_cnt++;
        end
      end
      prev_scl_hi = scl_hi;
      prev_sda    = sda_bus;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_end(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_o || err_o) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic new_run(input int div, input int nack_idx);
    nack_at   = nack_idx;
    byte_cnt  = 0;
    divider_i = DIV_W'(div);
    expect_run(div, nack_idx);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    // R1: idle after reset
    chk(!scl_drv_low && !sda_drv_low, "R1", "lines released", {scl_drv_low, sda_drv_low}, 0);
    chk(!done_o && !err_o, "R1", "flags low", {done_o, err_o}, 0);

    // R4 R5: nominal divider 31 -> 07 C0
    new_run(31, -1);
    pulse_start();
    wait_end(ok);
    chk(done_o && !err_o, "R7", "done after commit", {done_o, err_o}, 2);
    chk(exp_q.size() == 0, "R4", "all script items seen", exp_q.size(), 0);
    repeat (60) @(negedge clk);
    chk(done_o, "R7", "done held", done_o, 1);

    // R10 R8 R5: restart, second start ignored, divider changed mid-run
    new_run(1023, -1);
    pulse_start();
    @(negedge clk);
    chk(!done_o && !err_o, "R10", "flags cleared on start", {done_o, err_o}, 0);
    repeat (200) @(negedge clk);
    divider_i = '0;
    pulse_start();
    wait_end(ok);
    chk(done_o && !err_o, "R8", "run completes once", {done_o, err_o}, 2);
    repeat (500) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "no duplicated script", exp_q.size(), 0);
    chk(!scl_drv_low && !sda_drv_low, "R8", "bus idle after run", {scl_drv_low, sda_drv_low}, 0);

    // R6: NACK on register byte of the second transaction (byte index 4)
    new_run(31, 4);
    pulse_start();
    wait_end(ok);
    chk(err_o && !done_o, "R6", "error on nack", {done_o, err_o}, 1);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "script halted", exp_q.size(), 0);
    chk(err_o, "R6", "error held", err_o, 1);
    chk(!scl_drv_low && !sda_drv_low, "R6", "lines released after abort", {scl_drv_low, sda_drv_low}, 0);

    // R6: NACK on the very first address byte
    new_run(31, 0);
    pulse_start();
    wait_end(ok);
    chk(err_o && !done_o, "R6", "error on address nack", {done_o, err_o}, 1);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "stop right after address", exp_q.size(), 0);

    // R10 R5: restart after error with divider 0 -> 00 00
    new_run(0, -1);
    pulse_start();
    @(negedge clk);
    chk(!err_o, "R10", "error cleared on start", err_o, 0);
    wait_end(ok);
    chk(done_o && !err_o, "R10", "full run after error", {done_o, err_o}, 2);
    chk(exp_q.size() == 0, "R5", "zero divider bytes", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule